// File: doc/BRIEF.md
# Integer-N Synthesizer Divider and Phase Detector Core

This block is the digital heart of an integer-N frequency synthesizer. The crystal clock is divided by a selectable reference ratio to make the comparison pulse, and the oscillator clock is divided by a 15-bit programmable word. A phase/frequency detector compares the two pulse trains and produces pump-up and pump-down requests. A lock detector watches how wide those requests are.

A 3-bit mode input can override the pump requests for alignment: forced sink, forced source, pump off, or the power-on state that also releases the tuning output. The same mode picks what drives the clock output: the crystal clock, a divided main-path signal, a divided reference signal, or nothing. The two input clocks are slow square waves sampled by the system clock, so all logic runs in one clock domain. Register contents arrive as plain inputs from a separate control block.

Top module: `synth_core`

## Requirements
- R1: The reference select code maps to a ratio as 3'b000→2, 3'b001→4, 3'b010→8, 3'b101→16, 3'b111→32. One comparison pulse is made for every ratio-many rising edges of `xtal_in`, and `clk_out` in mode 3'b101 flips once per comparison pulse.
- R2: The codes 3'b011, 3'b100 and 3'b110 divide by 2. `ref_err` is 1 while such a code is applied and 0 for legal codes.
- R3: The main divider makes one pulse per `div_word` rising edges of `vco_in` for words from 64 to 32767. Words below 64 divide by 64. `clk_out` in mode 3'b000 flips once per main divider pulse.
- R4: A new divider word or reference code is taken up only at the divider's next terminal count. The interval in progress completes with the old ratio.
- R5: The comparison pulse sets the up request and the main divider pulse sets the down request. When both are set they clear after RST_DLY (2) cycles, so both are never high for more than RST_DLY consecutive cycles. A faster reference gives more up time than down time, and a faster main path gives the reverse.
- R6: Mode 3'b001 forces `cp_dn`=1 and `cp_up`=0 and sets `tune_hiz`=1. In every other mode `tune_hiz` is 0.
- R7: Mode 3'b011 forces sink (dn=1, up=0), 3'b110 forces both requests to 0, and 3'b111 forces source (up=1, dn=0). Modes 3'b000, 3'b010, 3'b100 and 3'b101 pass the detector's requests through.
- R8: `clk_out` follows `xtal_in` in modes 3'b001, 3'b011, 3'b100, 3'b110 and 3'b111. It is held at 0 in mode 3'b010.
- R9: `cp_cur` equals `cp_sel` in every mode.
- R10: `lock` rises after LOCK_CYC (16) consecutive comparison intervals in which no up-only or down-only run lasts longer than LOCK_TOL (4) cycles. It falls as soon as such a run exceeds the tolerance.
- R11: `lock` reads 0 in every mode other than 3'b100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_in | input | 1 | Crystal clock, sampled by `clk` |
| vco_in | input | 1 | Oscillator-side clock, sampled by `clk` |
| mode | input | 3 | Operating/test mode |
| ref_sel | input | 3 | Reference ratio code |
| cp_sel | input | 2 | Charge pump current level code |
| div_word | input | 15 | Main divider ratio |
| cp_up | output | 1 | Pump-up (source) request |
| cp_dn | output | 1 | Pump-down (sink) request |
| cp_cur | output | 2 | Charge pump current code |
| tune_hiz | output | 1 | Release tuning output to high impedance |
| clk_out | output | 1 | Selected clock/test output |
| lock | output | 1 | Loop lock indication |
| ref_err | output | 1 | Unsupported reference code applied |

## Verification
The dividers are run with every reference code, including the three unsupported ones. The main divider gets the minimum word, a word below the minimum and random words, and the measured output interval separates a correct ratio from an off-by-one or a wrong decode. Ratio changes applied mid-interval show whether an update takes effect at once or at the terminal count. The detector is driven with a faster reference, a faster main path, and exactly matched frequency and phase. These three cases separate up-dominant, down-dominant and locked behaviour. The lock case also stops the oscillator to check that lock falls. Every mode is then applied, in order and at random, on top of a known steady pump-up or pump-down request to check the overrides.

// File: rtl/synth_pkg.sv
`timescale 1ns/1ps
// Package: shared mode codes and reference ratio decode for the synthesizer core.
// Assumes a 3-bit mode and a 3-bit sparse reference code.
package synth_pkg;

    localparam int REF_RATIO_W = 6;

    typedef enum logic [2:0] {
        MODE_DIVTEST = 3'b000,
        MODE_POR     = 3'b001,
        MODE_MUTE    = 3'b010,
        MODE_SINK    = 3'b011,
        MODE_NORMAL  = 3'b100,
        MODE_REFTEST = 3'b101,
        MODE_OFF     = 3'b110,
        MODE_SOURCE  = 3'b111
    } synth_mode_e;

    // Decode the sparse reference code; unsupported codes fall back to 2.
    function automatic logic [REF_RATIO_W-1:0] ref_ratio(input logic [2:0] code);
        case (code)
            3'b000:  ref_ratio = REF_RATIO_W'(2);
            3'b001:  ref_ratio = REF_RATIO_W'(4);
            3'b010:  ref_ratio = REF_RATIO_W'(8);
            3'b101:  ref_ratio = REF_RATIO_W'(16);
            3'b111:  ref_ratio = REF_RATIO_W'(32);
            default: ref_ratio = REF_RATIO_W'(2);
        endcase
    endfunction

    // Flag the three codes that have no ratio assigned.
    function automatic logic ref_code_bad(input logic [2:0] code);
        ref_code_bad = (code == 3'b011) || (code == 3'b100) || (code == 3'b110);
    endfunction

endpackage

// File: rtl/edge_div.sv
`timescale 1ns/1ps
// Module: edge_div
// Counts tick strobes and emits a one-cycle pulse plus a toggling output
// every 'ratio' ticks. The ratio is captured at reset and again at each
// terminal count, so a change never shortens the interval in progress.
// Assumes ratio >= 2.
module edge_div #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         pulse,
    output logic         tgl
);

    logic [W-1:0] cnt;
    logic [W-1:0] lim;
    logic         at_end;

    assign at_end = (cnt == lim - 1'b1);

    // Count ticks, wrap at the captured limit and reload the limit there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            lim   <= ratio;
            pulse <= 1'b0;
            tgl   <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (tick) begin
                if (at_end) begin
                    cnt   <= '0;
                    lim   <= ratio;
                    pulse <= 1'b1;
                    tgl   <= ~tgl;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pfd.sv
`timescale 1ns/1ps
// Module: pfd
// Phase/frequency detector: a reference pulse sets 'up', a divider pulse
// sets 'dn'. Once both are set they are held together for DLY cycles and
// then cleared, which keeps short corrections alive near zero phase error.
// Assumes pulses of one input arrive more than DLY+1 cycles apart.
module pfd #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_p,
    input  logic div_p,
    output logic up,
    output logic dn
);

    localparam int CW = (DLY < 2) ? 1 : $clog2(DLY + 1);

    logic [CW-1:0] ov_cnt;
    logic          both;
    logic          clr;

    assign both = up & dn;
    assign clr  = both && (ov_cnt == CW'(DLY - 1));

    // Set on the pulses; on clear keep only a pulse arriving in that cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else if (clr) begin
            up <= ref_p;
            dn <= div_p;
        end else begin
            if (ref_p) up <= 1'b1;
            if (div_p) dn <= 1'b1;
        end
    end

    // Count the cycles both requests have been set together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_cnt <= '0;
        end else if (both && !clr) begin
            ov_cnt <= ov_cnt + 1'b1;
        end else begin
            ov_cnt <= '0;
        end
    end

endmodule

// File: rtl/lock_det.sv
`timescale 1ns/1ps
// Module: lock_det
// Declares lock after CYC comparison intervals in a row where no
// up-only/down-only run exceeds TOL cycles; drops lock on the first run
// that does. Intervals are delimited by the reference pulse.
module lock_det #(
    parameter int TOL = 4,
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_p,
    input  logic up,
    input  logic dn,
    output logic lock
);

    localparam int RW = $clog2(TOL + 2);
    localparam int GW = (CYC < 2) ? 1 : $clog2(CYC);

    logic [RW-1:0] run;
    logic [GW-1:0] good;
    logic          bad;
    logic          err;
    logic          viol;

    assign err  = up ^ dn;
    assign viol = err && (run >= RW'(TOL));

    // Length of the current one-sided run, saturating past the tolerance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0;
        end else if (!err) begin
            run <= '0;
        end else if (run <= RW'(TOL)) begin
            run <= run + 1'b1;
        end
    end

    // Count clean intervals; any violation clears the count and the lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good <= '0;
            bad  <= 1'b0;
            lock <= 1'b0;
        end else if (viol) begin
            good <= '0;
            lock <= 1'b0;
            bad  <= ~ref_p;
        end else if (ref_p) begin
            bad <= 1'b0;
            if (bad) begin
                good <= '0;
            end else if (good == GW'(CYC - 1)) begin
                lock <= 1'b1;
            end else begin
                good <= good + 1'b1;
            end
        end
    end

endmodule

// File: rtl/synth_core.sv
`timescale 1ns/1ps
// Module: synth_core
// Digital core of an integer-N synthesizer: reference and main dividers,
// phase/frequency detector, lock detector, charge pump mode overrides and
// the clock output selector. xtal_in and vco_in are taken to be synchronous
// to clk and slower than clk/2; their rising edges are found by sampling.
module synth_core #(
    parameter int N_W      = 15,
    parameter int N_MIN    = 64,
    parameter int RST_DLY  = 2,
    parameter int LOCK_TOL = 4,
    parameter int LOCK_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xtal_in,
    input  logic             vco_in,
    input  logic [2:0]       mode,
    input  logic [2:0]       ref_sel,
    input  logic [1:0]       cp_sel,
    input  logic [N_W-1:0]   div_word,
    output logic             cp_up,
    output logic             cp_dn,
    output logic [1:0]       cp_cur,
    output logic             tune_hiz,
    output logic             clk_out,
    output logic             lock,
    output logic             ref_err
);
    import synth_pkg::*;

    localparam logic [N_W-1:0] N_FLOOR = N_W'(N_MIN);

    logic [1:0]             in_now;
    logic [1:0]             in_q;
    logic [1:0]             rise;
    logic [REF_RATIO_W-1:0] ref_ratio_w;
    logic [N_W-1:0]         main_ratio;
    logic                   cmp_p;
    logic                   ref_tgl;
    logic                   div_p;
    logic                   div_tgl;
    logic                   pfd_up;
    logic                   pfd_dn;
    logic                   lock_raw;
    synth_mode_e            md;

    assign in_now = {vco_in, xtal_in};
    assign rise   = in_now & ~in_q;

    // Previous samples of both input clocks for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= 2'b11;
        else        in_q <= in_now;
    end

    assign ref_ratio_w = ref_ratio(ref_sel);
    assign ref_err     = ref_code_bad(ref_sel);
    assign main_ratio  = (div_word < N_FLOOR) ? N_FLOOR : div_word;

    edge_div #(.W(REF_RATIO_W)) u_ref_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (rise[0]),
        .ratio (ref_ratio_w),
        .pulse (cmp_p),
        .tgl   (ref_tgl)
    );

    edge_div #(.W(N_W)) u_main_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (rise[1]),
        .ratio (main_ratio),
        .pulse (div_p),
        .tgl   (div_tgl)
    );

    pfd #(.DLY(RST_DLY)) u_pfd (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_p (cmp_p),
        .div_p (div_p),
        .up    (pfd_up),
        .dn    (pfd_dn)
    );

    lock_det #(.TOL(LOCK_TOL), .CYC(LOCK_CYC)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_p (cmp_p),
        .up    (pfd_up),
        .dn    (pfd_dn),
        .lock  (lock_raw)
    );

    assign md     = synth_mode_e'(mode);
    assign cp_cur = cp_sel;
    assign lock   = lock_raw && (md == MODE_NORMAL);

    // Mode decode: pump overrides, tuning release and clock output choice.
    always_comb begin
        cp_up    = pfd_up;
        cp_dn    = pfd_dn;
        tune_hiz = 1'b0;
        clk_out  = xtal_in;
        case (md)
            MODE_DIVTEST: clk_out = div_tgl;
            MODE_POR: begin
                cp_up    = 1'b0;
                cp_dn    = 1'b1;
                tune_hiz = 1'b1;
            end
            MODE_MUTE:    clk_out = 1'b0;
            MODE_SINK: begin
                cp_up = 1'b0;
                cp_dn = 1'b1;
            end
            MODE_NORMAL:  clk_out = xtal_in;
            MODE_REFTEST: clk_out = ref_tgl;
            MODE_OFF: begin
                cp_up = 1'b0;
                cp_dn = 1'b0;
            end
            MODE_SOURCE: begin
                cp_up = 1'b1;
                cp_dn = 1'b0;
            end
            default: clk_out = xtal_in;
        endcase
    end

endmodule

// File: rtl/synth_core_chk.sv
`timescale 1ns/1ps
// Module: synth_core_chk
// Property checker for synth_core, attached through bind below. Observes
// ports only; tracks the run of joint up/down requests with a counter.
module synth_core_chk #(
    parameter int RST_DLY = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       cp_up,
    input logic       cp_dn,
    input logic       tune_hiz,
    input logic       clk_out,
    input logic       lock
);

    logic [7:0] both_run;

    // Consecutive cycles in which both requests were seen high.
    always_ff @(posedge clk) begin
        if (!rst_n)              both_run <= '0;
        else if (cp_up && cp_dn) both_run <= (both_run == 8'hFF) ? both_run : both_run + 1'b1;
        else                     both_run <= '0;
    end

    a_r5_overlap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        !(cp_up && cp_dn && (both_run >= 8'(RST_DLY))));

    a_r6_por_sink_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b001) |-> (cp_dn && !cp_up && tune_hiz));

    a_r6_release_only_por: assert property (@(posedge clk) disable iff (!rst_n)
        tune_hiz |-> (mode == 3'b001));

    a_r7_forced_sink: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b011) |-> (cp_dn && !cp_up));

    a_r7_pump_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b110) |-> (!cp_dn && !cp_up));

    a_r7_forced_source: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b111) |-> (cp_up && !cp_dn));

    a_r8_output_muted: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b010) |-> !clk_out);

    a_r11_lock_normal_only: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> (mode == 3'b100));

endmodule

bind synth_core synth_core_chk #(.RST_DLY(RST_DLY)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .cp_up    (cp_up),
    .cp_dn    (cp_dn),
    .tune_hiz (tune_hiz),
    .clk_out  (clk_out),
    .lock     (lock)
);

// File: tb/synth_core_bench.sv
`timescale 1ns/1ps
// Bench for synth_core: directed corner cases plus seeded random modes,
// ratios and current codes, checked against values computed here.
module synth_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_in = 1'b0;
    logic        vco_in = 1'b0;
    logic [2:0]  mode = 3'b100;
    logic [2:0]  ref_sel = 3'b000;
    logic [1:0]  cp_sel = 2'b00;
    logic [14:0] div_word = 15'd64;
    logic        cp_up, cp_dn, tune_hiz, clk_out, lock, ref_err;
    logic [1:0]  cp_cur;

    int n_cmp = 0;
    int n_mis = 0;
    int cyc = 0;
    bit done = 0;

    bit xrun = 0, vrun = 0;
    int xper = 4, vper = 2, xdly = 0, vdly = 0, xcnt = 0, vcnt = 0;

    synth_core u_synth_core (
        .clk(clk), .rst_n(rst_n), .xtal_in(xtal_in), .vco_in(vco_in),
        .mode(mode), .ref_sel(ref_sel), .cp_sel(cp_sel), .div_word(div_word),
        .cp_up(cp_up), .cp_dn(cp_dn), .cp_cur(cp_cur), .tune_hiz(tune_hiz),
        .clk_out(clk_out), .lock(lock), .ref_err(ref_err)
    );

    always #10 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // Square-wave sources for the crystal and oscillator sides.
    initial forever begin
        @(negedge clk);
        xtal_in = xrun && (xcnt >= xdly) && (((xcnt - xdly) % xper) < xper / 2);
        vco_in  = vrun && (vcnt >= vdly) && (((vcnt - vdly) % vper) < vper / 2);
        if (xrun) xcnt++; else xcnt = 0;
        if (vrun) vcnt++; else vcnt = 0;
    end

    function automatic int exp_ratio(input logic [2:0] c);
        case (c)
            3'b000: return 2;
            3'b001: return 4;
            3'b010: return 8;
            3'b101: return 16;
            3'b111: return 32;
            default: return 2;
        endcase
    endfunction

    function automatic bit exp_bad(input logic [2:0] c);
        return (c == 3'b011) || (c == 3'b100) || (c == 3'b110);
    endfunction

    function automatic bit exp_up(input logic [2:0] m, input bit raw);
        case (m)
            3'b001, 3'b011, 3'b110: return 1'b0;
            3'b111: return 1'b1;
            default: return raw;
        endcase
    endfunction

    function automatic bit exp_dn(input logic [2:0] m, input bit raw);
        case (m)
            3'b001, 3'b011: return 1'b1;
            3'b110, 3'b111: return 1'b0;
            default: return raw;
        endcase
    endfunction

    function automatic bit xtal_mode(input logic [2:0] m);
        return (m == 3'b001) || (m == 3'b011) || (m == 3'b100) || (m == 3'b110) || (m == 3'b111);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_mis++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        end
    endtask

    task automatic sample;
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [2:0] m, input logic [2:0] rs, input logic [14:0] dw);
        @(posedge clk); #2;
        xrun = 0; vrun = 0;
        rst_n = 0; mode = m; ref_sel = rs; div_word = dw;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
    endtask

    task automatic start_wave(input int xp, input int xd, input bit xr,
                              input int vp, input int vd, input bit vr);
        @(posedge clk); #2;
        xper = xp; xdly = xd; vper = vp; vdly = vd;
        xcnt = 0; vcnt = 0;
        xrun = xr; vrun = vr;
    endtask

    task automatic next_change(output int t);
        logic p;
        sample();
        p = clk_out;
        t = -1;
        for (int i = 0; i < 100000; i++) begin
            sample();
            if (clk_out !== p) begin
                t = cyc;
                break;
            end
        end
    endtask

    task automatic meas(output int dt);
        int a, b;
        next_change(a);
        next_change(b);
        dt = b - a;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_mis++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        int dt, t0, t1, t2, w;
        int upc, dnc, run, maxrun;
        logic [2:0] codes [8];
        void'($urandom(32'd4711));

        // Reset state in normal mode.
        do_reset(3'b100, 3'b000, 15'd64);
        sample();
        chk("R5 reset up", cp_up, 0);
        chk("R5 reset dn", cp_dn, 0);
        chk("R10 reset lock", lock, 0);
        chk("R6 reset tune_hiz", tune_hiz, 0);

        // R1 / R2: every reference code, reference toggle interval.
        for (int c = 0; c < 8; c++) begin
            do_reset(3'b101, 3'(c), 15'd64);
            start_wave(4, 0, 1, 2, 0, 0);
            sample();
            chk($sformatf("R2 ref_err code %0d", c), ref_err, exp_bad(3'(c)));
            next_change(t0);
            meas(dt);
            chk($sformatf("R1 R2 ref interval code %0d", c), dt, exp_ratio(3'(c)) * 4);
        end

        // R3: main divider words including floor, below floor and random.
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: w = 64;
                1: w = 10;
                2: w = 65;
                default: w = 64 + $urandom_range(0, 236);
            endcase
            do_reset(3'b000, 3'b000, 15'(w));
            start_wave(4, 0, 0, 2, 0, 1);
            next_change(t0);
            meas(dt);
            chk($sformatf("R3 main interval word %0d", w), dt, 2 * ((w < 64) ? 64 : w));
        end

        // R4: main word change mid-interval.
        do_reset(3'b000, 3'b000, 15'd100);
        start_wave(4, 0, 0, 2, 0, 1);
        next_change(t0);
        next_change(t1);
        repeat (20) @(posedge clk);
        #2 div_word = 15'd70;
        next_change(t2);
        chk("R4 main old ratio kept", t2 - t1, 200);
        next_change(t0);
        chk("R4 main new ratio", t0 - t2, 140);

        // R4: reference code change mid-interval.
        do_reset(3'b101, 3'b010, 15'd64);
        start_wave(4, 0, 1, 2, 0, 0);
        next_change(t0);
        next_change(t1);
        repeat (10) @(posedge clk);
        #2 ref_sel = 3'b111;
        next_change(t2);
        chk("R4 ref old ratio kept", t2 - t1, 32);
        next_change(t0);
        chk("R4 ref new ratio", t0 - t2, 128);

        // R5: fast reference then fast main path.
        for (int k = 0; k < 2; k++) begin
            do_reset(3'b100, (k == 0) ? 3'b000 : 3'b111, 15'd64);
            start_wave((k == 0) ? 4 : 8, 0, 1, 2, 0, 1);
            upc = 0; dnc = 0; run = 0; maxrun = 0;
            for (int i = 0; i < 1024; i++) begin
                sample();
                if (cp_up && !cp_dn) upc++;
                if (cp_dn && !cp_up) dnc++;
                if (cp_up && cp_dn) run++; else run = 0;
                if (run > maxrun) maxrun = run;
            end
            if (k == 0) chk("R5 up dominates", upc > dnc, 1);
            else        chk("R5 dn dominates", dnc > upc, 1);
            chk("R5 overlap bound", maxrun <= 2, 1);
        end

        // R6 R7 R8 R9 R11: every mode over a steady raw request.
        codes = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b110, 3'b111};
        for (int r = 0; r < 2; r++) begin
            do_reset(3'b100, 3'b000, 15'd64);
            if (r == 0) start_wave(4, 0, 1, 2, 0, 0);
            else        start_wave(4, 0, 0, 2, 0, 1);
            repeat (300) @(posedge clk);
            for (int i = 0; i < 20; i++) begin
                logic [2:0] m;
                logic [1:0] cs;
                m  = (i < 8) ? codes[i] : 3'($urandom_range(0, 7));
                cs = 2'($urandom_range(0, 3));
                @(posedge clk); #2;
                mode = m; cp_sel = cs;
                sample();
                chk($sformatf("R6 R7 up mode %0d", m), cp_up, exp_up(m, r == 0));
                chk($sformatf("R6 R7 dn mode %0d", m), cp_dn, exp_dn(m, r == 1));
                chk($sformatf("R6 tune_hiz mode %0d", m), tune_hiz, m == 3'b001);
                chk($sformatf("R9 cp_cur mode %0d", m), cp_cur, cs);
                chk($sformatf("R11 lock mode %0d", m), lock, 0);
                if (r == 0 && (xtal_mode(m) || m == 3'b010)) begin
                    int bad;
                    bad = 0;
                    for (int j = 0; j < 8; j++) begin
                        sample();
                        if (clk_out !== (xtal_mode(m) ? xtal_in : 1'b0)) bad++;
                    end
                    chk($sformatf("R8 clk_out mode %0d", m), bad, 0);
                end
            end
        end

        // R10 R11: matched frequency and phase, then loss of oscillator.
        do_reset(3'b100, 3'b000, 15'd64);
        start_wave(64, 62, 1, 2, 0, 1);
        repeat (1500) @(posedge clk);
        sample();
        chk("R10 no early lock", lock, 0);
        repeat (1500) @(posedge clk);
        sample();
        chk("R10 lock reached", lock, 1);
        @(posedge clk); #2 mode = 3'b000;
        sample();
        chk("R11 lock hidden mode 0", lock, 0);
        @(posedge clk); #2 mode = 3'b101;
        sample();
        chk("R11 lock hidden mode 5", lock, 0);
        @(posedge clk); #2 mode = 3'b100;
        sample();
        chk("R10 R11 lock kept", lock, 1);
        @(posedge clk); #2 vrun = 0;
        repeat (200) @(posedge clk);
        sample();
        chk("R10 lock lost", lock, 0);

        summary();
        $finish;
    end

endmodule